// File: doc/BRIEF.md
# Domain-Relative Pointer Address Mangler

This block sits between a load/store unit and the address path. Every pointer it accepts becomes an effective global address one clock later. The top bit of a pointer is a local flag. A pointer with that flag clear is already global, so it goes out unchanged. A pointer with the flag set is relocated: the flag is stripped, then the pointer is XORed with a base value. The base value is the one that belongs to the protection domain issuing the access. XOR is used instead of an add so that the relocation costs a single gate level on the address path.

The block keeps one base value per domain in a small register table, and that table resets to all zeros. A privileged agent writes an entry through a separate write port. The typical case is moving a forked child's local ranges into a free part of the global space. Relocation is applied on every accepted pointer, so a new base value affects every later use of an existing local pointer.

Top module: `ptr_mangler`

## Requirements
- R1: After reset `out_valid` is 0, `out_addr` is 0, and every domain's base value is 0.
- R2: `out_valid` in a cycle equals `in_valid` of the previous cycle.
- R3: An accepted pointer with bit 63 clear appears unchanged on `out_addr` one cycle later.
- R4: An accepted pointer with bit 63 set produces, one cycle later, `out_addr` = (pointer with bit 63 forced to 0) XOR base[`in_dom`].
- R5: The base value used is the one indexed by the 4-bit `in_dom` given with that pointer. Different domains use their own entries.
- R6: A write (`wr_en`=1) to entry `wr_dom` is used by pointers accepted in later cycles. A pointer accepted in the same cycle as a write to its own domain uses the old value.
- R7: While a domain's base value is zero, a local pointer comes out as the pointer with bit 63 cleared.
- R8: When `in_valid` is 0, `out_addr` keeps its previous value.
- R9: A write to one domain's entry leaves the results for every other domain unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A pointer is presented this cycle |
| in_ptr | input | 64 | Pointer; bit 63 is the local flag |
| in_dom | input | 4 | Domain issuing the access |
| wr_en | input | 1 | Privileged base write strobe |
| wr_dom | input | 4 | Domain entry being written |
| wr_base | input | 64 | New base value |
| out_valid | output | 1 | Effective address is valid |
| out_addr | output | 64 | Effective global address |

## Verification
The assertions assume that `in_valid`, `wr_en` and the index inputs are known, 0 or 1 on every bit, in every cycle after reset. They also assume that a pointer's domain id is sampled in the same cycle as the pointer; no other ordering of inputs is assumed. The stimulus drives every input at the falling edge from bench variables that always hold defined values. Domain ids are drawn over the full 4-bit range. Writes are scattered among valid and idle cycles, and some deliberately hit the domain being looked up in that same cycle.

// File: rtl/ptr_mangle_pkg.sv
package ptr_mangle_pkg;
   localparam int unsigned DEF_ADDR_W = 64;
   localparam int unsigned DEF_DOM_W  = 4;

   function automatic logic [DEF_ADDR_W-1:0] top_bit_mask();
      logic [DEF_ADDR_W-1:0] m;
      m = '0;
      m[DEF_ADDR_W-1] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/base_table.sv
module base_table #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned DEPTH = 1 << IDX_W;

   logic [DATA_W-1:0] ent [DEPTH];

   generate
      if (IDX_W < 1 || IDX_W > 8) begin : g_bad_idx
         $error("base_table: IDX_W out of range");
      end
      for (genvar i = 0; i < DEPTH; i++) begin : g_ent
         always_ff @(posedge clk) begin
            if (!rst_n)
               ent[i] <= '0;
            else if (wr_en && wr_idx == IDX_W'(i))
               ent[i] <= wr_data;
         end
      end
   endgenerate

   // Read reflects the stored value, so a same-cycle write is not visible yet.
   assign rd_data = ent[rd_idx];

   // R6: a write lands in its entry by the next cycle
   p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en && rst_n) |-> ent[$past(wr_idx)] == $past(wr_data));

   // R1: entries are zero right after reset
   p_reset_zero_r1: assert property (@(posedge clk)
      $past(!rst_n) |-> rd_data == '0);
endmodule

// File: rtl/addr_xform.sv
module addr_xform #(
   parameter int unsigned ADDR_W     = 64,
   parameter bit          CLEAR_FLAG = 1'b1
) (
   input  logic [ADDR_W-1:0] ptr,
   input  logic [ADDR_W-1:0] base,
   output logic [ADDR_W-1:0] addr
);
   localparam int unsigned FLAG_POS = ADDR_W - 1;

   logic              is_local;
   logic [ADDR_W-1:0] stripped;

   assign is_local = ptr[FLAG_POS];

   generate
      if (ADDR_W < 2) begin : g_bad_w
         $error("addr_xform: ADDR_W must be at least 2");
      end
      if (CLEAR_FLAG) begin : g_strip
         assign stripped = {1'b0, ptr[FLAG_POS-1:0]};
      end else begin : g_keep
         assign stripped = ptr;
      end
   endgenerate

   always_comb begin
      if (is_local)
         addr = stripped ^ base;
      else
         addr = ptr;
   end

   // R3: global pointers are untouched
   always_comb begin
      if (!is_local)
         a_global_same_r3: assert (addr == ptr);
   end
endmodule

// File: rtl/ptr_mangler.sv
module ptr_mangler
   import ptr_mangle_pkg::*;
#(
   parameter int unsigned ADDR_W = DEF_ADDR_W,
   parameter int unsigned DOM_W  = DEF_DOM_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] in_ptr,
   input  logic [DOM_W-1:0]  in_dom,
   input  logic              wr_en,
   input  logic [DOM_W-1:0]  wr_dom,
   input  logic [ADDR_W-1:0] wr_base,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_addr
);
   localparam int unsigned FLAG_POS = ADDR_W - 1;

   logic [ADDR_W-1:0] cur_base;
   logic [ADDR_W-1:0] eff_addr;

   base_table #(.DATA_W(ADDR_W), .IDX_W(DOM_W)) u_tab (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_dom),
      .wr_data (wr_base),
      .rd_idx  (in_dom),
      .rd_data (cur_base)
   );

   addr_xform #(.ADDR_W(ADDR_W), .CLEAR_FLAG(1'b1)) u_xf (
      .ptr  (in_ptr),
      .base (cur_base),
      .addr (eff_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_addr  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid)
            out_addr <= eff_addr;
      end
   end

   // R2: valid is delayed by exactly one cycle
   p_valid_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == ($past(in_valid) && $past(rst_n)));

   // R3: global pointer leaves the block unchanged
   p_global_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && in_valid && !in_ptr[FLAG_POS]) |-> out_addr == $past(in_ptr));

   // R4: local pointer output keeps flag only through base bit
   p_local_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && in_valid && in_ptr[FLAG_POS]) |->
         out_addr[FLAG_POS] == $past(cur_base[FLAG_POS]));

   // R8: idle cycles keep the last address
   p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && !in_valid) |-> $stable(out_addr));
endmodule

// File: tb/tb_ptr_mangler.sv
module tb_ptr_mangler;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [63:0] in_ptr;
   logic [3:0]  in_dom;
   logic        wr_en;
   logic [3:0]  wr_dom;
   logic [63:0] wr_base;
   logic        out_valid;
   logic [63:0] out_addr;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   logic [63:0] model [16];
   logic [63:0] exp_addr;
   logic        exp_valid;

   always #4 clk = ~clk;

   ptr_mangler dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ptr(in_ptr),
      .in_dom(in_dom), .wr_en(wr_en), .wr_dom(wr_dom), .wr_base(wr_base),
      .out_valid(out_valid), .out_addr(out_addr)
   );

   function automatic logic [63:0] mangle(logic [63:0] p, logic [63:0] b);
      if (p[63]) return {1'b0, p[62:0]} ^ b;
      return p;
   endfunction

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Drive at negedge, sample 2 ns after the following posedge.
   task automatic step(string tag, bit v, logic [63:0] p, logic [3:0] d,
                       bit we, logic [3:0] wd, logic [63:0] wb);
      @(negedge clk);
      in_valid = v; in_ptr = p; in_dom = d;
      wr_en = we; wr_dom = wd; wr_base = wb;
      if (v) exp_addr = mangle(p, model[d]);
      exp_valid = v;
      @(posedge clk);
      if (we) model[wd] = wb;
      #2;
      check({tag, " valid"}, {63'd0, out_valid}, {63'd0, exp_valid});
      check({tag, " addr"}, out_addr, exp_addr);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      for (int i = 0; i < 16; i++) model[i] = '0;
      rst_n = 1'b0; in_valid = 0; in_ptr = '0; in_dom = '0;
      wr_en = 0; wr_dom = '0; wr_base = '0;
      exp_addr = '0; exp_valid = 0;
      repeat (3) @(posedge clk);
      #2;
      check("R1 reset valid", {63'd0, out_valid}, 64'd0);
      check("R1 reset addr", out_addr, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;

      step("R3 global", 1, 64'h0123_4567_89AB_CDEF, 4'd2, 0, 0, 0);
      step("R7 zero base local", 1, 64'h8000_0000_DEAD_BEEF, 4'd9, 0, 0, 0);
      step("R8 idle hold", 0, 64'h8FFF_FFFF_FFFF_FFFF, 4'd1, 0, 0, 0);
      step("R2 idle again", 0, 64'h0, 4'd0, 0, 0, 0);
      // R6: same-cycle write and lookup on domain 5 uses old (zero) value
      step("R6 same cycle old", 1, 64'h8000_0000_0000_1000, 4'd5,
           1, 4'd5, 64'h0000_0F00_0000_0000);
      step("R6 next uses new", 1, 64'h8000_0000_0000_1000, 4'd5, 0, 0, 0);
      step("R9 write dom 6", 1, 64'h8000_0000_0000_2222, 4'd5,
           1, 4'd6, 64'h1234_0000_0000_0000);
      step("R5 dom 6 own base", 1, 64'h8000_0000_0000_2222, 4'd6, 0, 0, 0);
      step("R9 dom 5 unchanged", 1, 64'h8000_0000_0000_2222, 4'd5, 0, 0, 0);
      step("R4 base top bit", 1, 64'h8000_0000_0000_0001, 4'd7,
           1, 4'd7, 64'hC000_0000_0000_0000);
      step("R4 base top bit used", 1, 64'h8000_0000_0000_0001, 4'd7, 0, 0, 0);
      step("R3 global ignores base", 1, 64'h0000_0000_0000_0001, 4'd7, 0, 0, 0);

      for (int n = 0; n < 400; n++) begin
         logic [63:0] p;
         p = {$urandom, $urandom};
         step("R4/R3/R5 random", ($urandom % 4) != 0, p, 4'($urandom),
              ($urandom % 3) == 0, 4'($urandom), {$urandom, $urandom});
      end

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule